// File: doc/BRIEF.md
# Dual-Group Parallel I/O Controller

A bus-attached digital I/O peripheral with 48 lines, split into two identical groups of 24. Each group has three byte-wide ports (call them A, B and C) and a control register. A host reaches the block through a byte-wide read/write port that decodes a 4-bit offset. A mode word written to a group's control register sets the direction of port A and port B as whole bytes, and of port C one nibble at a time. A control word with bit 7 clear leaves the mode alone and sets or clears a single port C bit. Output latches drive the pins and come with per-bit output enables. Reading a port gives the pin value on input bits and the latch value on output bits.

A small interrupt unit watches bit 3 of each group's port C. Each of these two inputs passes through a two-flop synchronizer. When interrupts are enabled, a rising edge on either one sets a sticky pending flag, which drives the single interrupt request. A write to offset 0xB enables interrupts and a read from offset 0xB disables them. A write to offset 0xF clears the pending flag once the host has serviced it.

Top module: `pio48_ctrl`

## Requirements
- R1: Offsets 0, 1 and 2 select group 0 ports A, B and C, and offset 3 selects its control register. Offsets 4 to 7 select the same four registers of group 1. Pins `[24g+7:24g]` belong to port A of group g, `[24g+15:24g+8]` to port B and `[24g+23:24g+16]` to port C.
- R2: A control write with bit 7 set is a mode word. Bit 4 set makes port A an input, bit 1 set makes port B an input, bit 3 set makes port C bits 7:4 an input and bit 0 set makes port C bits 3:0 an input. A cleared bit makes that part an output, and `pins_oe` is high exactly on output bits.
- R3: A mode word clears all three output latches of its group to zero.
- R4: A control write with bit 7 clear leaves the mode unchanged. It sets the port C latch bit selected by write bits 3:1 to the value of write bit 0, and leaves the other latch bits as they were.
- R5: A port read returns the pin value on bits configured as inputs and the latch value on bits configured as outputs. A data write always updates the latch, including while the port is an input.
- R6: A control register read returns the last mode word written to that group.
- R7: After reset every port is an input, the mode reads back as 0x9B, all latches and `pins_oe` are zero, interrupts are disabled and `irq` is low.
- R8: The interrupt sources are pins 19 and 43 (bit 3 of each port C). After a rising edge on either source pin, `irq` goes high at the third rising clock edge. A falling edge has no effect.
- R9: A write to offset 0xB enables interrupts and a read from offset 0xB disables them. An edge that arrives while interrupts are disabled is ignored.
- R10: The pending flag is sticky and stays high after the source pin falls. A write to offset 0xF clears it, and `irq` is low at the next clock edge.
- R11: Both groups drive the one shared `irq` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| pins_in | input | 48 | Pin input values |
| pins_out | output | 48 | Output latch values |
| pins_oe | output | 48 | Output enable per pin |
| irq | output | 1 | Shared interrupt request |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is combinational, so the bench checks it 1 ns after it sets up a read, which is still before that edge. Pin outputs and enables are checked one cycle after the write that changes them. Interrupt timing is counted from the negative edge at which a source pin rises. `irq` must still be low after two rising edges and high after the third. A clear is checked at the negative edge after the write to 0xF, so each check samples the first cycle in which the requirement allows the change and never an earlier one.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned GRP_PORTS = 3;
  localparam int unsigned GRP_W     = BYTE_W * GRP_PORTS;
  localparam int unsigned ADDR_W    = 4;

  // mode word bit positions
  localparam int unsigned MB_SET  = 7;
  localparam int unsigned MB_A_IN = 4;
  localparam int unsigned MB_CH_IN = 3;
  localparam int unsigned MB_B_IN = 1;
  localparam int unsigned MB_CL_IN = 0;

  localparam logic [BYTE_W-1:0] MODE_RST = 8'h9B;

  localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 4'hB;
  localparam logic [ADDR_W-1:0] OFS_IRQ_CLR = 4'hF;
  localparam logic [1:0]        OFS_CTRL    = 2'd3;

  // bit of port C used as interrupt source
  localparam int unsigned IRQ_BIT = 2 * BYTE_W + 3;
endpackage

// File: rtl/pio_group.sv
module pio_group
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        offs,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [GRP_W-1:0]  pins_in,
  output logic [BYTE_W-1:0] rdata,
  output logic [GRP_W-1:0]  pins_out,
  output logic [GRP_W-1:0]  pins_oe
);
  logic [BYTE_W-1:0]                 mode_q, mode_d;
  logic [GRP_PORTS-1:0][BYTE_W-1:0]  lat_q, lat_d;
  logic [GRP_PORTS-1:0][BYTE_W-1:0]  oe_w, pin_w;
  logic                              ctrl_wr;

  assign ctrl_wr = wr_en && (offs == OFS_CTRL);

  always_comb begin
    mode_d = mode_q;
    lat_d  = lat_q;
    if (wr_en) begin
      if (offs == OFS_CTRL) begin
        if (wdata[MB_SET]) begin
          mode_d = wdata;
          lat_d  = '0;
        end else begin
          lat_d[2][wdata[3:1]] = wdata[0];
        end
      end else begin
        lat_d[offs] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      lat_q  <= '0;
    end else if (wr_en) begin
      mode_q <= mode_d;
      lat_q  <= lat_d;
    end
  end

  always_comb begin
    oe_w[0] = {BYTE_W{~mode_q[MB_A_IN]}};
    oe_w[1] = {BYTE_W{~mode_q[MB_B_IN]}};
    oe_w[2] = {{(BYTE_W/2){~mode_q[MB_CH_IN]}}, {(BYTE_W/2){~mode_q[MB_CL_IN]}}};
  end

  assign pin_w    = pins_in;
  assign pins_out = lat_q;
  assign pins_oe  = oe_w;

  always_comb begin
    if (offs == OFS_CTRL) rdata = mode_q;
    else rdata = (pin_w[offs] & ~oe_w[offs]) | (lat_q[offs] & oe_w[offs]);
  end

  a_r3_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[MB_SET] |=> (pins_out == '0));
  a_r4_bitop_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wdata[MB_SET] |=> $stable(pins_oe));
  a_r4_bitop_keeps_ab: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wdata[MB_SET] |=> $stable(pins_out[2*BYTE_W-1:0]));
endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            en_set,
  input  logic            en_clr,
  input  logic            pend_clr,
  output logic            irq
);
  logic [NSRC-1:0] sync1_q, sync2_q, prev_q, edge_w;
  logic            en_q, en_d, pend_q, pend_d;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync1_q[i] <= 1'b0;
          sync2_q[i] <= 1'b0;
          prev_q[i]  <= 1'b0;
        end else begin
          sync1_q[i] <= src[i];
          sync2_q[i] <= sync1_q[i];
          prev_q[i]  <= sync2_q[i];
        end
      end
      assign edge_w[i] = sync2_q[i] & ~prev_q[i];
    end
  endgenerate

  always_comb begin
    en_d = en_q;
    if (en_set)      en_d = 1'b1;
    else if (en_clr) en_d = 1'b0;
    pend_d = (pend_q & ~pend_clr) | (en_q & (|edge_w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign irq = pend_q;

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !pend_clr |=> irq);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr && !(|edge_w) |=> !irq);
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !irq |=> !irq);
  a_r8_rise_has_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !irq ##1 irq |-> $past(|(sync2_q & ~prev_q)));
endmodule

// File: rtl/pio48_ctrl.sv
module pio48_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned NGRP = 2,
  localparam int unsigned PIN_W = NGRP * GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pins_in,
  output logic [PIN_W-1:0]  pins_out,
  output logic [PIN_W-1:0]  pins_oe,
  output logic              irq
);
  logic [NGRP-1:0][BYTE_W-1:0] grp_rdata;
  logic [NGRP-1:0]             grp_irq_src;
  logic                        in_grp;

  assign in_grp = ~bus_addr[3];

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      pio_group u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && in_grp && (bus_addr[2] == g[0])),
        .offs     (bus_addr[1:0]),
        .wdata    (bus_wdata),
        .pins_in  (pins_in[g*GRP_W +: GRP_W]),
        .rdata    (grp_rdata[g]),
        .pins_out (pins_out[g*GRP_W +: GRP_W]),
        .pins_oe  (pins_oe[g*GRP_W +: GRP_W])
      );
      assign grp_irq_src[g] = pins_in[g*GRP_W + IRQ_BIT];
    end
  endgenerate

  assign bus_rdata = in_grp ? grp_rdata[bus_addr[2]] : '0;

  pio_irq #(.NSRC(NGRP)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (grp_irq_src),
    .en_set   (bus_wr && (bus_addr == OFS_IRQ_EN)),
    .en_clr   (bus_rd && (bus_addr == OFS_IRQ_EN)),
    .pend_clr (bus_wr && (bus_addr == OFS_IRQ_CLR)),
    .irq      (irq)
  );

  a_r7_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);
endmodule

// File: tb/pio48_ctrl_bench.sv
module pio48_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [47:0] pins_in, pins_out, pins_oe;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  pio48_ctrl u_pio48_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
  );

  // {req[3:0], is_read, addr[3:0], data_or_expected[7:0]}
  localparam int NV = 28;
  localparam logic [16:0] VEC [NV] = '{
    {4'd7, 1'b1, 4'h3, 8'h9B},  // R7 reset mode
    {4'd5, 1'b1, 4'h0, 8'hA5},  // R5 inputs read pins
    {4'd1, 1'b1, 4'h4, 8'h5A},  // R1 group 1 port A
    {4'd5, 1'b0, 4'h0, 8'h77},
    {4'd5, 1'b1, 4'h0, 8'hA5},  // R5 latch hidden while input
    {4'd2, 1'b0, 4'h3, 8'h80},
    {4'd3, 1'b1, 4'h0, 8'h00},  // R3 latch 0x77 cleared
    {4'd1, 1'b0, 4'h0, 8'h3E},
    {4'd5, 1'b1, 4'h0, 8'h3E},
    {4'd1, 1'b0, 4'h1, 8'hF0},
    {4'd5, 1'b1, 4'h1, 8'hF0},
    {4'd2, 1'b0, 4'h3, 8'h88},
    {4'd3, 1'b1, 4'h0, 8'h00},  // R3
    {4'd1, 1'b0, 4'h2, 8'hFF},
    {4'd5, 1'b1, 4'h2, 8'h6F},  // R5 mixed nibbles
    {4'd4, 1'b0, 4'h3, 8'h04},  // R4 clear bit 2
    {4'd4, 1'b1, 4'h2, 8'h6B},
    {4'd6, 1'b1, 4'h3, 8'h88},  // R6 mode kept
    {4'd1, 1'b0, 4'h7, 8'h91},
    {4'd1, 1'b0, 4'h5, 8'h12},
    {4'd1, 1'b0, 4'h6, 8'hA0},
    {4'd5, 1'b1, 4'h4, 8'h5A},
    {4'd5, 1'b1, 4'h5, 8'h12},
    {4'd5, 1'b1, 4'h6, 8'hA1},
    {4'd4, 1'b0, 4'h7, 8'h0E},  // R4 clear bit 7
    {4'd4, 1'b1, 4'h6, 8'h21},
    {4'd6, 1'b1, 4'h7, 8'h91},
    {4'd1, 1'b1, 4'h0, 8'h00}
  };

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(tag, {40'd0, bus_rdata}, {40'd0, exp});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    pins_in = {8'h91, 8'hC3, 8'h5A, 8'h62, 8'h3C, 8'hA5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 irq low", {47'd0, irq}, 48'd0);
    chk("R7 all inputs", pins_oe, 48'd0);
    chk("R7 latches zero", pins_out, 48'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12]) rd_chk($sformatf("R%0d vector %0d", VEC[i][16:13], i), VEC[i][11:8], VEC[i][7:0]);
      else            wr(VEC[i][11:8], VEC[i][7:0]);
    end

    chk("R2 output enables", pins_oe, {8'hF0, 8'hFF, 8'h00, 8'h0F, 8'hFF, 8'hFF});
    chk("R3 R4 latch pins", pins_out, {8'h20, 8'h12, 8'h00, 8'hFB, 8'h00, 8'h00});

    // R9: edge while disabled is ignored
    pins_in[19] = 1'b1;
    cycles(4);
    chk("R9 disabled edge", {47'd0, irq}, 48'd0);
    pins_in[19] = 1'b0;
    cycles(3);

    // R8: enable, rising edge, exact latency
    wr(4'hB, 8'h00);
    pins_in[19] = 1'b1;
    cycles(2);
    chk("R8 not before third edge", {47'd0, irq}, 48'd0);
    cycles(1);
    chk("R8 third edge", {47'd0, irq}, 48'd1);
    pins_in[19] = 1'b0;
    cycles(4);
    chk("R10 sticky after fall", {47'd0, irq}, 48'd1);
    wr(4'hF, 8'h00);
    chk("R10 cleared", {47'd0, irq}, 48'd0);
    cycles(3);
    chk("R8 falling edge ignored", {47'd0, irq}, 48'd0);

    // R11: group 1 source on the shared line
    pins_in[43] = 1'b1;
    cycles(3);
    chk("R11 group 1 edge", {47'd0, irq}, 48'd1);
    wr(4'hF, 8'h00);
    chk("R11 cleared", {47'd0, irq}, 48'd0);
    pins_in[43] = 1'b0;
    cycles(3);

    // R9: read of 0xB disables
    rd_chk("R9 disable read data", 4'hB, 8'h00);
    pins_in[19] = 1'b1;
    cycles(4);
    chk("R9 disabled by read", {47'd0, irq}, 48'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule